// File: doc/BRIEF.md
# Load Area Address Checker

This block decides whether a table of 16-byte entries, which is to be loaded when a virtual machine is entered, lies at a usable address. A request carries the table's 64-bit base address, a 32-bit entry count, the processor's physical-address width and a mode bit. The mode bit says whether the processor is 64-bit capable or 32-bit only. The block checks two things: the base alignment, and that both the base and the address of the table's last byte fit inside the addressable range. It reports a pass/fail verdict and one flag per violated rule.

A request is presented with `req_valid` for one cycle. The response appears with `rsp_valid` exactly two cycles later. A new request may be presented in every cycle. The block does not fetch the table, and it does not discover the address width by itself: the surrounding logic supplies it. An empty table (count zero) needs no checks and always passes.

The last-byte address is base + count·16 − 1. The block computes it in a 69-bit sum split across the two pipeline stages. A table that runs past the top of the 64-bit space therefore shows up as a set high bit. It cannot wrap around to a small in-range address.

Top module: `load_area_checker`

## Requirements
- R1: A request accepted with `req_valid` high at clock edge n gives `rsp_valid` high after edge n+2 for one cycle. Cycles without a request give no response.
- R2: When the entry count is zero, the response has `rsp_pass`=1 and all error flags 0, whatever the base, width and mode.
- R3: With a non-zero count, `rsp_err_align` is 1 exactly when base bits 3:0 are not all zero.
- R4: In 64-bit-capable mode (`req_wide`=1) with a legal width W, `rsp_err_base` is 1 exactly when the base has a bit set at position W or above.
- R5: In 32-bit-only mode (`req_wide`=0), `rsp_err_base` is 1 exactly when base bits 63:32 are not all zero. In this mode the width input has no effect.
- R6: `rsp_err_end` is 1 exactly when the last-byte address base + count·16 − 1 has a bit set at or above the active limit. The active limit is W in 64-bit-capable mode and 32 in 32-bit-only mode.
- R7: The last-byte sum does not wrap at 2^64. A table whose end passes 2^64 − 1 sets `rsp_err_end`.
- R8: In 64-bit-capable mode, a width outside 32..52 sets `rsp_err_width` and forces `rsp_err_base` and `rsp_err_end` to 0. It never sets `rsp_err_width` in 32-bit-only mode.
- R9: `rsp_pass` is 1 exactly when no error flag is set in the response.
- R10: Requests on consecutive cycles are judged independently, each with its own response two cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_base | input | 64 | Table base address |
| req_count | input | 32 | Number of 16-byte entries |
| req_paw | input | 8 | Physical-address width in bits |
| req_wide | input | 1 | 1: 64-bit-capable processor, 0: 32-bit-only |
| rsp_valid | output | 1 | Response strobe |
| rsp_pass | output | 1 | Table address acceptable |
| rsp_err_align | output | 1 | Base not 16-byte aligned |
| rsp_err_base | output | 1 | Base outside addressable range |
| rsp_err_end | output | 1 | Last byte outside addressable range |
| rsp_err_width | output | 1 | Width value out of the legal range |

## Verification
Two functions can coincide in one response. The first is the base-range check, done in the first stage. The second is the end-range check, which only finishes in the second stage from the pipelined sum. The bench provokes both together with bases just below, at and above each width boundary, combined with counts that push only the end across, or both. The near-top base with a two-entry count makes the end pass 2^64 while the base is also out of range. Each response is judged against a 69-bit model computed in the bench, and back-to-back requests make sure the stage-two result for one request never mixes with the stage-one flags of the next.

// File: rtl/load_area_pkg.sv
package load_area_pkg;

   // Per-rule verdict carried from stage one to the output stage.
   typedef struct packed {
      logic empty;
      logic align;
      logic base_far;
      logic width_bad;
   } lac_stage_t;

endpackage

// File: rtl/lac_limit_decode.sv
module lac_limit_decode #(
   parameter int PAW_W        = 8,
   parameter int LIM_W        = 7,
   parameter int PAW_MIN      = 32,
   parameter int PAW_MAX      = 52,
   parameter int NARROW_LIMIT = 32
) (
   input  logic [PAW_W-1:0] paw,
   input  logic             wide,
   output logic [LIM_W-1:0] limit,
   output logic             width_bad
);

   generate
      if (LIM_W > PAW_W) begin : g_bad_lim
         initial $error("LIM_W must not exceed PAW_W");
      end
      if (PAW_MAX >= (1 << LIM_W)) begin : g_bad_max
         initial $error("PAW_MAX does not fit the limit field");
      end
   endgenerate

   always_comb begin
      width_bad = 1'b0;
      limit     = LIM_W'(NARROW_LIMIT);
      if (wide) begin
         if ((paw < PAW_W'(PAW_MIN)) || (paw > PAW_W'(PAW_MAX))) begin
            width_bad = 1'b1;
         end else begin
            limit = paw[LIM_W-1:0];
         end
      end
   end

endmodule

// File: rtl/lac_range_check.sv
module lac_range_check #(
   parameter int W     = 64,
   parameter int LIM_W = 7
) (
   input  logic [W-1:0]     value,
   input  logic [LIM_W-1:0] limit,
   output logic             out_of_range
);

   localparam int IW = $clog2(W) + 1;

   logic [W-1:0] above;

   // One threshold comparator per bit position: shallow and shifter-free.
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign above[i] = (IW'(i) >= IW'(limit));
      end
   endgenerate

   assign out_of_range = |(value & above);

endmodule

// File: rtl/lac_end_adder.sv
module lac_end_adder #(
   parameter int W     = 69,
   parameter int LO_W  = 34,
   parameter bit SPLIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);

   localparam int HI_W = W - LO_W;

   generate
      if (LO_W < 1 || LO_W >= W) begin : g_bad_split
         initial $error("LO_W must lie inside the sum width");
      end

      if (SPLIT) begin : g_split
         logic [LO_W:0]   lo_q;
         logic [HI_W-1:0] ahi_q;
         logic [HI_W-1:0] bhi_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lo_q  <= '0;
               ahi_q <= '0;
               bhi_q <= '0;
            end else if (en) begin
               lo_q  <= {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
               ahi_q <= a[W-1:LO_W];
               bhi_q <= b[W-1:LO_W];
            end
         end

         assign sum = {ahi_q + bhi_q + HI_W'(lo_q[LO_W]), lo_q[LO_W-1:0]};
      end else begin : g_flat
         logic [W-1:0] sum_q;

         always_ff @(posedge clk) begin
            if (!rst_n)  sum_q <= '0;
            else if (en) sum_q <= a + b;
         end

         assign sum = sum_q;
      end
   endgenerate

   // R6: the pipelined sum equals the full sum of the operands one cycle back.
   p_sum_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (sum == ($past(a) + $past(b))));

endmodule

// File: rtl/load_area_checker.sv
module load_area_checker
   import load_area_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int CNT_W        = 32,
   parameter int ENTRY_SHIFT  = 4,
   parameter int PAW_W        = 8,
   parameter int PAW_MIN      = 32,
   parameter int PAW_MAX      = 52,
   parameter int NARROW_LIMIT = 32,
   parameter bit SPLIT_ADD    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [CNT_W-1:0]  req_count,
   input  logic [PAW_W-1:0]  req_paw,
   input  logic              req_wide,
   output logic              rsp_valid,
   output logic              rsp_pass,
   output logic              rsp_err_align,
   output logic              rsp_err_base,
   output logic              rsp_err_end,
   output logic              rsp_err_width
);

   localparam int SPAN_W = CNT_W + ENTRY_SHIFT;
   localparam int SUM_W  = ADDR_W + ENTRY_SHIFT + 1;
   localparam int LO_W   = SUM_W / 2;
   localparam int LIM_W  = $clog2(ADDR_W + 1);

   generate
      if (SPAN_W > ADDR_W) begin : g_bad_span
         initial $error("table span wider than the address");
      end
      if (NARROW_LIMIT >= ADDR_W || NARROW_LIMIT < 1) begin : g_bad_narrow
         initial $error("NARROW_LIMIT must lie inside the address");
      end
      if (ENTRY_SHIFT < 1) begin : g_bad_shift
         initial $error("ENTRY_SHIFT must be at least 1");
      end
   endgenerate

   // ---------------- stage one: per-request decode ----------------
   logic [LIM_W-1:0]  lim_d;
   logic              width_bad_d;
   logic              base_far_d;
   logic [SPAN_W-1:0] span_d;
   logic [SUM_W-1:0]  add_a;
   logic [SUM_W-1:0]  add_b;
   lac_stage_t        st_d;

   lac_limit_decode #(
      .PAW_W        (PAW_W),
      .LIM_W        (LIM_W),
      .PAW_MIN      (PAW_MIN),
      .PAW_MAX      (PAW_MAX),
      .NARROW_LIMIT (NARROW_LIMIT)
   ) u_limit (
      .paw       (req_paw),
      .wide      (req_wide),
      .limit     (lim_d),
      .width_bad (width_bad_d)
   );

   lac_range_check #(
      .W     (ADDR_W),
      .LIM_W (LIM_W)
   ) u_base_rng (
      .value        (req_base),
      .limit        (lim_d),
      .out_of_range (base_far_d)
   );

   // count*16 - 1 == {count-1, all ones}; only used when count is non-zero.
   assign span_d = {req_count - CNT_W'(1), {ENTRY_SHIFT{1'b1}}};
   assign add_a  = {{(SUM_W-ADDR_W){1'b0}}, req_base};
   assign add_b  = {{(SUM_W-SPAN_W){1'b0}}, span_d};

   always_comb begin
      st_d.empty     = (req_count == '0);
      st_d.align     = |req_base[ENTRY_SHIFT-1:0];
      st_d.base_far  = base_far_d;
      st_d.width_bad = width_bad_d;
   end

   logic             s1_valid;
   lac_stage_t       s1_st;
   logic [LIM_W-1:0] s1_lim;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_st    <= '0;
         s1_lim   <= '0;
      end else begin
         s1_valid <= req_valid;
         if (req_valid) begin
            s1_st  <= st_d;
            s1_lim <= lim_d;
         end
      end
   end

   // ---------------- end-address sum across both stages ----------------
   logic [SUM_W-1:0] end_sum;
   logic             end_far;

   lac_end_adder #(
      .W     (SUM_W),
      .LO_W  (LO_W),
      .SPLIT (SPLIT_ADD)
   ) u_end_add (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (req_valid),
      .a     (add_a),
      .b     (add_b),
      .sum   (end_sum)
   );

   lac_range_check #(
      .W     (SUM_W),
      .LIM_W (LIM_W)
   ) u_end_rng (
      .value        (end_sum),
      .limit        (s1_lim),
      .out_of_range (end_far)
   );

   // ---------------- stage two: verdict ----------------
   logic v_align;
   logic v_base;
   logic v_end;
   logic v_width;

   always_comb begin
      v_align = 1'b0;
      v_base  = 1'b0;
      v_end   = 1'b0;
      v_width = 1'b0;
      if (!s1_st.empty) begin
         v_align = s1_st.align;
         v_width = s1_st.width_bad;
         v_base  = s1_st.base_far & ~s1_st.width_bad;
         v_end   = end_far & ~s1_st.width_bad;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_pass      <= 1'b0;
         rsp_err_align <= 1'b0;
         rsp_err_base  <= 1'b0;
         rsp_err_end   <= 1'b0;
         rsp_err_width <= 1'b0;
      end else begin
         rsp_valid     <= s1_valid;
         rsp_pass      <= s1_valid & ~(v_align | v_base | v_end | v_width);
         rsp_err_align <= s1_valid & v_align;
         rsp_err_base  <= s1_valid & v_base;
         rsp_err_end   <= s1_valid & v_end;
         rsp_err_width <= s1_valid & v_width;
      end
   end

   // ---------------- assertions ----------------
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ##1 rsp_valid);

   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ##1 !rsp_valid);

   p_empty_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_count == '0, 2)) |->
         (rsp_pass && !rsp_err_align && !rsp_err_base && !rsp_err_end && !rsp_err_width));

   p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past((req_count != '0) && (|req_base[ENTRY_SHIFT-1:0]), 2)) |->
         (rsp_err_align && !rsp_pass));

   p_narrow_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past((req_count != '0) && !req_wide &&
                          (|req_base[ADDR_W-1:NARROW_LIMIT]), 2)) |-> rsp_err_base);

   p_width_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past((req_count != '0) && req_wide &&
                          ((req_paw < PAW_W'(PAW_MIN)) || (req_paw > PAW_W'(PAW_MAX))), 2)) |->
         (rsp_err_width && !rsp_err_base && !rsp_err_end && !rsp_pass));

endmodule

// File: tb/load_area_checker_test.sv
`timescale 1ns/1ps
module load_area_checker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_base = '0;
   logic [31:0] req_count = '0;
   logic [7:0]  req_paw = '0;
   logic        req_wide = 1'b0;
   logic        rsp_valid, rsp_pass, rsp_err_align, rsp_err_base, rsp_err_end, rsp_err_width;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   load_area_checker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
      .req_count(req_count), .req_paw(req_paw), .req_wide(req_wide),
      .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_err_align(rsp_err_align),
      .rsp_err_base(rsp_err_base), .rsp_err_end(rsp_err_end), .rsp_err_width(rsp_err_width));

   // {pass, align, base, end, width}
   function automatic logic [4:0] model(input logic [63:0] b, input logic [31:0] c,
                                        input logic [7:0] p, input logic w);
      logic [68:0] e;
      int lim;
      logic wb, al, bb, eb;
      if (c == 0) return 5'b10000;
      al  = (b[3:0] != 4'd0);
      wb  = 1'b0;
      lim = 32;
      if (w) begin
         if (p < 8'd32 || p > 8'd52) wb = 1'b1;
         else lim = int'(p);
      end
      e  = {5'd0, b} + {33'd0, c, 4'd0} - 69'd1;
      bb = !wb && (({5'd0, b} >> lim) != 69'd0);
      eb = !wb && ((e >> lim) != 69'd0);
      return {!(al | bb | eb | wb), al, bb, eb, wb};
   endfunction

   function automatic logic [4:0] got();
      return {rsp_pass, rsp_err_align, rsp_err_base, rsp_err_end, rsp_err_width};
   endfunction

   task automatic chk(input string tag, input logic exp_valid, input logic [4:0] exp);
      checks++;
      if (rsp_valid !== exp_valid || (exp_valid && got() !== exp)) begin
         errors++;
         $display("FAIL %s: got valid=%b flags=%b expected valid=%b flags=%b",
                  tag, rsp_valid, got(), exp_valid, exp);
      end
   endtask

   task automatic drive(input logic [63:0] b, input logic [31:0] c,
                        input logic [7:0] p, input logic w);
      req_valid = 1'b1;
      req_base  = b;
      req_count = c;
      req_paw   = p;
      req_wide  = w;
   endtask

   // Called at a falling edge; returns at the falling edge where the result was sampled.
   task automatic run_one(input string tag, input logic [63:0] b, input logic [31:0] c,
                          input logic [7:0] p, input logic w);
      drive(b, c, p, w);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 one cycle after request", 1'b0, 5'b0);
      @(negedge clk);
      chk(tag, 1'b1, model(b, c, p, w));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("reset state R1", 1'b0, 5'b0);
      checks++;
      if (rsp_pass !== 1'b0 || got() !== 5'b0) begin
         errors++;
         $display("FAIL reset: got flags=%b expected 00000", got());
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2: empty tables pass regardless of other inputs
      run_one("R2 empty misaligned wide", 64'hFFFF_FFFF_FFFF_FFF7, 32'd0, 8'd52, 1'b1);
      run_one("R2 empty bad width", 64'h1234, 32'd0, 8'd7, 1'b1);
      run_one("R2 empty narrow high", 64'h0000_0001_0000_0000, 32'd0, 8'd0, 1'b0);

      // R3: alignment on each low bit
      for (int k = 0; k < 16; k++) begin
         run_one("R3 alignment", 64'h1000 | 64'(k), 32'd1, 8'd40, 1'b1);
      end

      // R4, R6, R8, R9: sweep width across and past the legal range at the boundaries
      for (int p = 28; p <= 56; p++) begin
         for (int bi = 0; bi < 4; bi++) begin
            for (int ci = 0; ci < 3; ci++) begin
               logic [63:0] b;
               logic [31:0] c;
               case (bi)
                  0: b = (64'd1 << p) - 64'd16;
                  1: b = (64'd1 << p);
                  2: b = (64'd1 << p) - 64'd32;
                  default: b = 64'h1000;
               endcase
               case (ci)
                  0: c = 32'd1;
                  1: c = 32'd2;
                  default: c = 32'h1000_0000;
               endcase
               run_one((p < 32 || p > 52) ? "R8 width sweep" : "R4 R6 R9 width sweep",
                       b, c, 8'(p), 1'b1);
            end
         end
      end

      // R5: 32-bit-only mode, width input ignored
      for (int q = 0; q < 4; q++) begin
         logic [7:0] pw;
         pw = (q == 0) ? 8'd0 : (q == 1) ? 8'd40 : (q == 2) ? 8'd200 : 8'd32;
         run_one("R5 narrow base fits", 64'hFFFF_FFF0, 32'd1, pw, 1'b0);
         run_one("R5 narrow base high", 64'h0000_0001_0000_0000, 32'd1, pw, 1'b0);
         run_one("R5 R6 narrow end over", 64'hFFFF_FFF0, 32'd2, pw, 1'b0);
         run_one("R6 narrow big count", 64'hFFFF_FF00, 32'hFFFF_FFFF, pw, 1'b0);
      end

      // R7: end passes 2^64 without wrapping
      run_one("R7 end wraps wide", 64'hFFFF_FFFF_FFFF_FFF0, 32'd2, 8'd52, 1'b1);
      run_one("R7 end wraps narrow", 64'hFFFF_FFFF_FFFF_FFF0, 32'hFFFF_FFFF, 8'd0, 1'b0);
      run_one("R7 end at top", 64'hFFFF_FFFF_FFFF_FFF0, 32'd1, 8'd52, 1'b1);

      // R10: back-to-back requests
      for (int r = 0; r < 3; r++) begin
         logic [63:0] b1, b2;
         logic [31:0] c1, c2;
         b1 = (r == 0) ? 64'h10 : 64'hFFFF_FFF8;
         c1 = 32'd1;
         b2 = (r == 1) ? 64'h0000_0001_0000_0000 : 64'h2000;
         c2 = (r == 2) ? 32'd0 : 32'h0FFF_FFFF;
         drive(b1, c1, 8'd36, 1'b1);
         @(negedge clk);
         drive(b2, c2, 8'd36, 1'b1);
         @(negedge clk);
         req_valid = 1'b0;
         chk("R10 first of pair", 1'b1, model(b1, c1, 8'd36, 1'b1));
         @(negedge clk);
         chk("R10 second of pair", 1'b1, model(b2, c2, 8'd36, 1'b1));
         @(negedge clk);
         chk("R1 idle after pair", 1'b0, 5'b0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule